// File: doc/BRIEF.md
# MRU-protected set-associative replacement tracker

This block holds the replacement bookkeeping for a set-associative cache: a valid flag for every entry and a small recency record for every set. The tag comparison and the data storage sit elsewhere. Each cycle the cache presents the set it is working on. The block answers combinationally with that set's valid flags, its most recently used way, and the way a fill would use. When the access is a hit, the cache reports the way that matched, and the block marks it as most recent at the next clock edge. When the access is a fill, the block writes into the way it proposed, sets that way's valid flag, and marks it as most recent.

A parameter chooses between two organisations. In the four-way organisation each set keeps a two-bit pointer to its most recently used way. A fill never evicts that way. An outside two-bit pseudo-random value picks among the other three. In the two-way organisation each set keeps one bit that names its least recently used way, and that way is the one evicted. In both organisations an invalid way is used before any valid way. A single flush input, raised on a context switch, clears every valid flag in one cycle.

Top module: `repl_tracker`

## Requirements
- R1: After reset every set reports all valid flags clear. In the four-way organisation the most recently used way reads 0. In the two-way organisation the recorded least recently used way is 0, so the most recently used way reads 1.
- R2: An access with acc_valid=1 and acc_hit=1 makes acc_way the most recently used way of acc_set from the next clock edge. Valid flags do not change.
- R3: When a set has at least one clear valid flag, vic_way is the lowest-numbered invalid way. A fill (acc_valid=1, acc_hit=0) sets that way's valid flag and makes it most recently used from the next clock edge. acc_way is ignored on a fill.
- R4: When all ways of the set are valid, vic_way never equals mru_way.
- R5: Four-way, set full: the three non-MRU ways are taken in ascending order as list positions 0, 1 and 2. rnd values 0, 1 and 2 select the position with the same number, and rnd value 3 selects position 0.
- R6: flush=1 clears every valid flag of every set and returns every recency record to its reset value at the next edge. It takes priority over an access in the same cycle.
- R7: Two-way organisation: each set keeps one bit naming its least recently used way. A full set evicts that way. Any hit or fill on way w sets the bit to the other way. rnd has no effect.
- R8: An access changes only the state of acc_set. All other sets keep their valid flags and recency records.
- R9: With acc_valid=0 and flush=0 no state changes, whatever the values of acc_hit, acc_way and rnd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| flush | input | 1 | Invalidate every entry (context switch) |
| acc_valid | input | 1 | Access to acc_set this cycle |
| acc_hit | input | 1 | 1 = hit on acc_way, 0 = fill into vic_way |
| acc_set | input | SET_W | Set being looked up or updated |
| acc_way | input | WAY_W | Way that matched on a hit |
| rnd | input | 2 | External pseudo-random selector (four-way only) |
| vic_way | output | WAY_W | Way a fill of acc_set would write |
| mru_way | output | WAY_W | Most recently used way of acc_set |
| set_valid | output | WAYS | Valid flags of acc_set, bit w for way w |

## Verification
The bench drives a full set through every combination of MRU way and rnd value. A design that counted from the wrong base, or let rnd value 3 fall through, would evict the protected way or skip a candidate. It fills sets from empty to check that invalid ways are used lowest first, which catches a design that trusts rnd while free ways remain. It also raises flush in the same cycle as a fill, which catches a flush that loses to the access. Idle cycles with garbage on acc_hit, acc_way and rnd are followed by reads of the same set, so a design that updates without acc_valid shows a changed mru_way. Separate sets are accessed in turn, so a decoder that spills a write into a neighbouring set also shows up.

// File: rtl/repl_pkg.sv
package repl_pkg;

  // Map a 2-bit random value onto the three ways other than 'mru',
  // taken in ascending order; value 3 folds onto the first candidate.
  function automatic logic [1:0] skip_mru(input logic [1:0] mru,
                                          input logic [1:0] rnd);
    logic [1:0] pos;
    pos = (rnd == 2'd3) ? 2'd0 : rnd;
    return (pos >= mru) ? pos + 2'd1 : pos;
  endfunction

endpackage

// File: rtl/repl_rst_sync.sv
module repl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/repl_state_array.sv
module repl_state_array #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int SET_W = 6,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             wr_fill,
  input  logic [SET_W-1:0] sel_set,
  input  logic [WAY_W-1:0] wr_way,
  output logic [WAYS-1:0]  rd_valid,
  output logic [WAY_W-1:0] rd_ptr
);
  // Two-way keeps the least recent way, four-way keeps the most recent.
  localparam bit PTR_IS_LRU = (WAYS == 2);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [WAY_W-1:0] ptr_q   [SETS];
  logic [WAY_W-1:0] ptr_d   [SETS];
  logic             upd_en;

  assign upd_en = flush | wr_en;

  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (flush) begin
      for (int s = 0; s < SETS; s++) begin
        valid_d[s] = '0;
        ptr_d[s]   = '0;
      end
    end else if (wr_en) begin
      ptr_d[sel_set] = PTR_IS_LRU ? ~wr_way : wr_way;
      if (wr_fill) valid_d[sel_set][wr_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
      end
    end else if (upd_en) begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  assign rd_valid = valid_q[sel_set];
  assign rd_ptr   = ptr_q[sel_set];
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel
  import repl_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] ptr,
  input  logic [1:0]       rnd,
  output logic [WAY_W-1:0] victim,
  output logic [WAY_W-1:0] mru
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] policy_way;

  // Lowest-numbered invalid way wins.
  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  generate
    if (WAYS == 4) begin : g_mru_protect
      assign mru        = ptr;
      assign policy_way = skip_mru(ptr, rnd);
    end else begin : g_lru_bit
      logic unused_rnd;
      assign unused_rnd = ^rnd;
      assign mru        = ~ptr;
      assign policy_way = ptr;
    end
  endgenerate

  assign victim = any_free ? free_way : policy_way;
endmodule

// File: rtl/repl_tracker.sv
module repl_tracker #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [1:0]       rnd,
  output logic [WAY_W-1:0] vic_way,
  output logic [WAY_W-1:0] mru_way,
  output logic [WAYS-1:0]  set_valid
);
  logic             rst_sync_n;
  logic             wr_en;
  logic             wr_fill;
  logic [WAY_W-1:0] wr_way;
  logic [WAY_W-1:0] cur_ptr;

  repl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_en   = acc_valid & ~flush;
  assign wr_fill = ~acc_hit;
  assign wr_way  = acc_hit ? acc_way : vic_way;

  repl_state_array #(
    .SETS (SETS), .WAYS (WAYS), .SET_W (SET_W), .WAY_W (WAY_W)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flush    (flush),
    .wr_en    (wr_en),
    .wr_fill  (wr_fill),
    .sel_set  (acc_set),
    .wr_way   (wr_way),
    .rd_valid (set_valid),
    .rd_ptr   (cur_ptr)
  );

  repl_victim_sel #(
    .WAYS (WAYS), .WAY_W (WAY_W)
  ) u_vsel (
    .valid  (set_valid),
    .ptr    (cur_ptr),
    .rnd    (rnd),
    .victim (vic_way),
    .mru    (mru_way)
  );
endmodule

// File: rtl/repl_tracker_chk.sv
module repl_tracker_chk #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             acc_valid,
  input logic             acc_hit,
  input logic [SET_W-1:0] acc_set,
  input logic [WAY_W-1:0] acc_way,
  input logic [WAY_W-1:0] vic_way,
  input logic [WAY_W-1:0] mru_way,
  input logic [WAYS-1:0]  set_valid
);
  // R2: a hit makes the hit way most recent
  p_hit_mru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit && !flush) |=>
      (acc_set != $past(acc_set)) || (mru_way == $past(acc_way)));

  // R3: a fill leaves the filled way valid
  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && !flush) |=>
      (acc_set != $past(acc_set)) || set_valid[$past(vic_way)]);

  // R3: a free way is always preferred
  p_free_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(&set_valid) |-> !set_valid[vic_way]);

  // R4: the MRU way is never the victim of a full set
  p_vic_not_mru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&set_valid) |-> (vic_way != mru_way));

  // R6: flush clears the looked-up set
  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (set_valid == '0));

  // R9: no update without an access
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !flush) |=>
      (acc_set != $past(acc_set)) ||
      ((set_valid == $past(set_valid)) && (mru_way == $past(mru_way))));
endmodule

bind repl_tracker repl_tracker_chk #(
  .SETS (SETS), .WAYS (WAYS), .SET_W (SET_W), .WAY_W (WAY_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .flush     (flush),
  .acc_valid (acc_valid),
  .acc_hit   (acc_hit),
  .acc_set   (acc_set),
  .acc_way   (acc_way),
  .vic_way   (vic_way),
  .mru_way   (mru_way),
  .set_valid (set_valid)
);

// File: tb/sim_repl_tracker.sv
`timescale 1ns/1ps
module sim_repl_tracker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       flush;
  logic       av4, hit4, av2, hit2;
  logic [5:0] set4;
  logic [2:0] set2;
  logic [1:0] way4, rnd;
  logic [0:0] way2;
  logic [1:0] vic4, mru4;
  logic [3:0] sv4;
  logic [0:0] vic2, mru2;
  logic [1:0] sv2;

  repl_tracker #(.SETS(64), .WAYS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .acc_valid(av4), .acc_hit(hit4),
    .acc_set(set4), .acc_way(way4), .rnd(rnd),
    .vic_way(vic4), .mru_way(mru4), .set_valid(sv4));

  repl_tracker #(.SETS(8), .WAYS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .acc_valid(av2), .acc_hit(hit2),
    .acc_set(set2), .acc_way(way2), .rnd(rnd),
    .vic_way(vic2), .mru_way(mru2), .set_valid(sv2));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  int       m4_mru [64];
  bit [3:0] m4_v   [64];
  int       m2_lru [8];
  bit [1:0] m2_v   [8];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 64; s++) begin m4_mru[s] = 0; m4_v[s] = '0; end
    for (int s = 0; s < 8; s++)  begin m2_lru[s] = 0; m2_v[s] = '0; end
  endtask

  task automatic step(string tag, bit fl, bit a4, bit h4, int s4, int w4,
                      int r, bit a2, bit h2, int s2, int w2);
    int ev4, em4, ev2, em2;
    int q[$];
    flush = fl; av4 = a4; hit4 = h4; set4 = s4[5:0]; way4 = w4[1:0];
    rnd = r[1:0]; av2 = a2; hit2 = h2; set2 = s2[2:0]; way2 = w2[0:0];
    #1;
    em4 = m4_mru[s4];
    ev4 = -1;
    for (int w = 3; w >= 0; w--) if (!m4_v[s4][w]) ev4 = w;
    if (ev4 < 0) begin
      for (int w = 0; w < 4; w++) if (w != em4) q.push_back(w);
      ev4 = q[(r == 3) ? 0 : r];
    end
    em2 = 1 - m2_lru[s2];
    ev2 = -1;
    for (int w = 1; w >= 0; w--) if (!m2_v[s2][w]) ev2 = w;
    if (ev2 < 0) ev2 = m2_lru[s2];

    chk(tag, "u0 set_valid", int'(sv4), int'(m4_v[s4]));
    chk(tag, "u0 mru_way",   int'(mru4), em4);
    chk(tag, "u0 vic_way",   int'(vic4), ev4);
    chk(tag, "u1 set_valid", int'(sv2), int'(m2_v[s2]));
    chk(tag, "u1 mru_way",   int'(mru2), em2);
    chk(tag, "u1 vic_way",   int'(vic2), ev2);

    if (fl) model_clear();
    else begin
      if (a4) begin
        if (h4) m4_mru[s4] = w4;
        else begin m4_v[s4][ev4] = 1'b1; m4_mru[s4] = ev4; end
      end
      if (a2) begin
        if (h2) m2_lru[s2] = 1 - w2;
        else begin m2_v[s2][ev2] = 1'b1; m2_lru[s2] = 1 - ev2; end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 0; av4 = 0; hit4 = 0; av2 = 0; hit2 = 0;
    set4 = '0; set2 = '0; way4 = '0; way2 = '0; rnd = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of several sets
    for (int s = 0; s < 8; s++) step("R1", 0, 0, 0, s * 7, 0, 0, 0, 0, s, 0);

    // R3: fill set 9 from empty, acc_way garbage, lowest free first
    for (int k = 0; k < 4; k++) step("R3", 0, 1, 0, 9, 3 - k, k, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 9, 0, 0, 0, 0, 0, 0);

    // R2 / R4 / R5: every MRU way against every rnd value
    for (int m = 0; m < 4; m++) begin
      step("R2", 0, 1, 1, 9, m, 0, 0, 0, 0, 0);
      for (int r = 0; r < 4; r++) step("R5", 0, 0, 0, 9, 0, r, 0, 0, 0, 0);
    end
    // R4: fill a full set, protected way untouched
    step("R4", 0, 1, 0, 9, 0, 3, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 9, 0, 1, 0, 0, 0, 0);

    // R9: idle cycles with garbage on the access fields
    for (int k = 0; k < 4; k++) step("R9", 0, 0, k[0], 9, k, 3 - k, 0, k[1], 2, k);

    // R8: fill set 10, set 9 unchanged
    step("R8", 0, 1, 0, 10, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 1, 1, 10, 2, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 9, 0, 2, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 10, 0, 2, 0, 0, 0, 0);

    // R7: two-way fill order and LRU tracking
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0, 3, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0, 3, 0);
    step("R7", 0, 0, 0, 0, 0, 2, 0, 0, 3, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 1, 3, 0);
    step("R7", 0, 0, 0, 0, 0, 3, 0, 0, 3, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0, 3, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 0, 0, 3, 0);

    // R6: flush with a simultaneous fill, then read back
    step("R6", 1, 1, 0, 9, 0, 0, 1, 0, 3, 0);
    step("R6", 0, 0, 0, 9, 0, 0, 0, 0, 3, 0);
    step("R6", 0, 0, 0, 10, 0, 0, 0, 0, 3, 0);

    // R4/R5: random traffic on a few sets
    for (int k = 0; k < 3000; k++) begin
      int s4r, s2r;
      s4r = $urandom_range(0, 3);
      s2r = $urandom_range(0, 1);
      step("R4", ($urandom_range(0, 199) == 0), $urandom_range(0, 1),
           $urandom_range(0, 1), s4r, $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
           s2r, $urandom_range(0, 1));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule